// File: doc/BRIEF.md
# Windowed Raster Convolver

This block takes a raster video stream one pixel per valid clock and builds an 8-wide by 4-tall neighbourhood around the newest pixel. The vertical part of the window comes from three chained line delays. Each delay is a circular buffer whose length is set through a configuration port, up to 1024 pixels. The horizontal part comes from an 8-stage tap register on each of the four rows. Every window position is multiplied by its own signed 8-bit coefficient. The 32 products are added at 32-bit width, and the total is produced with a valid flag. Alongside the total, the block gives the oldest-row pixel that entered that same window.

The first row above the live row has two possible sources. For progressive video it comes from the internal first line delay. For interlaced video a select input replaces it with a pixel that arrives on a separate previous-field port. The later line delays then chain from whichever source is selected. An optional fixed 4-pixel delay can be placed on the live pixel before it enters the window and the line stores. A smaller kernel is obtained by writing zero to the coefficients it does not use.

Each line delay has a fill state machine with two states. LD_EMPTY is entered at reset, and in this state the delay outputs zero. The transition to LD_PRIMED takes place on the first pointer wrap, which is the first time the write pointer reaches the programmed length. LD_PRIMED has no exit other than reset, and in this state the delay returns the stored pixel.

Top module: `win_convolver`

## Requirements
- R1: With `cfg_line_len_m1 = L-1` (L from 1 to 1024), each line delay outputs the pixel written exactly L valid pixels earlier. Row 1 is one line delay behind row 0, row 2 is two delays behind, and row 3 is three delays behind.
- R2: `out_sum` equals the sum over r in 0..3 and c in 0..7 of coef[r*8+c] × tap(r,c). Here tap(r,c) is the row-r pixel c valid pixels before the newest one, and row 0 is the live row. The coefficient at address a = r*8+c is loaded through `coef_we`/`coef_addr`/`coef_data`.
- R3: Pixels are unsigned. Coefficients are two's complement. Every product is sign-extended and summed into a 32-bit two's complement result with no loss, including the extreme case of all coefficients at -128 with all pixels at 255 (sum -1044480).
- R4: After reset, all tap registers read zero, and each line delay outputs zero until it has received L pixels. Immediately after reset, `out_valid`, `out_sum` and `out_last` are zero.
- R5: When `field_sel` = 1, row 1 takes `prev_pix` in place of the first line delay output, and the second line delay is fed from that row.
- R6: When `cfg_pre_dly` = 2'b01, the live pixel passes through a 4-valid-pixel delay before it reaches row 0 and the first line delay. The values 00, 10 and 11 add no delay.
- R7: `out_valid` is `in_valid` delayed by two clocks. `out_sum` and `out_last` change only in cycles where `out_valid` is 1.
- R8: Clocks with `in_valid` = 0 advance no tap, line delay or pre-delay, and the pixel inputs on those clocks have no effect.
- R9: `out_last` equals tap(3,0) of the window that produced the accompanying `out_sum`.
- R10: A coefficient of zero removes its tap. A 3×3 kernel in rows 0..2 and columns 0..2, with the other 23 coefficients zero, yields exactly the 3×3 convolution.
- R11: Coefficients rewritten while `in_valid` is low apply to every pixel that arrives after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel inputs are valid this clock |
| live_pix | input | 8 | Live pixel, unsigned |
| prev_pix | input | 8 | Previous-field pixel, unsigned |
| field_sel | input | 1 | 1: row 1 taken from `prev_pix`; 0: from the first line delay |
| cfg_line_len_m1 | input | 10 | Line length minus one |
| cfg_pre_dly | input | 2 | 01 inserts a 4-pixel input delay; other values add none |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | 5 | Coefficient index, row*8 + column |
| coef_data | input | 8 | Coefficient, two's complement |
| out_valid | output | 1 | `out_sum` and `out_last` hold a new result |
| out_sum | output | 32 | Two's complement window sum |
| out_last | output | 8 | Row-3 newest pixel of the same window |

## Verification
The assertions rely on two conditions. `cfg_line_len_m1` must stay constant between resets, because the pointer-range property depends on it. `rst` must be high at time zero, so that the hold and latency properties start from known register values. The stimulus meets both conditions. Every scenario begins with a reset during which the line length, pre-delay code and field select are set, and these three inputs are not changed until the next reset. Coefficient writes are made only while `in_valid` is low, and the mid-stream reload starts at least two clocks after the last pixel so that its result has already been registered.

// File: rtl/cv_pkg.sv
package cv_pkg;
    typedef enum logic {
        LD_EMPTY,
        LD_PRIMED
    } ld_state_e;
endpackage

// File: rtl/cv_line_delay.sv
module cv_line_delay
    import cv_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int MAX_LEN = 1024,
    localparam int LEN_W  = $clog2(MAX_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [LEN_W-1:0] len_m1,
    input  logic [PIX_W-1:0] din,
    output logic [PIX_W-1:0] dout
);
    logic [PIX_W-1:0] mem [MAX_LEN];
    logic [LEN_W-1:0] ptr, ptr_nx;
    ld_state_e        st, st_nx;
    logic             wrap;

    assign wrap = (ptr >= len_m1);

    always_comb begin
        ptr_nx = ptr;
        st_nx  = st;
        if (en) begin
            ptr_nx = wrap ? '0 : ptr + LEN_W'(1);
        end
        unique case (st)
            LD_EMPTY:  if (en && wrap) st_nx = LD_PRIMED;
            LD_PRIMED: st_nx = LD_PRIMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= LD_EMPTY;
            ptr <= '0;
        end else begin
            st  <= st_nx;
            ptr <= ptr_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (en) mem[ptr] <= din;
    end

    always_comb begin
        unique case (st)
            LD_EMPTY:  dout = '0;
            LD_PRIMED: dout = mem[ptr];
        endcase
    end

    // R1: the pointer never leaves the programmed line
    p_ptr_in_len_r1: assert property (@(posedge clk) disable iff (rst)
        ptr <= len_m1);

    // R4: once primed, a delay never returns to the zero-output state
    p_primed_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        st == LD_PRIMED |=> st == LD_PRIMED);
endmodule

// File: rtl/cv_row_taps.sv
module cv_row_taps #(
    parameter int PIX_W = 8,
    parameter int COLS  = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic [PIX_W-1:0]      din,
    output logic [COLS*PIX_W-1:0] taps
);
    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= '0;
        end else if (en) begin
            taps <= {taps[(COLS-1)*PIX_W-1:0], din};
        end
    end
endmodule

// File: rtl/cv_mac.sv
module cv_mac #(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 8,
    parameter int ACC_W  = 32,
    parameter int NTAP   = 32
) (
    input  logic [NTAP*PIX_W-1:0]  win,
    input  logic [NTAP*COEF_W-1:0] coefs,
    output logic [ACC_W-1:0]       sum
);
    always_comb begin
        logic signed [ACC_W-1:0] acc;
        logic signed [ACC_W-1:0] cx;
        logic signed [ACC_W-1:0] px;
        acc = '0;
        for (int i = 0; i < NTAP; i++) begin
            cx  = {{(ACC_W-COEF_W){coefs[i*COEF_W+COEF_W-1]}}, coefs[i*COEF_W +: COEF_W]};
            px  = {{(ACC_W-PIX_W){1'b0}}, win[i*PIX_W +: PIX_W]};
            acc = acc + cx * px;
        end
        sum = acc;
    end
endmodule

// File: rtl/win_convolver.sv
module win_convolver #(
    parameter int PIX_W   = 8,
    parameter int COEF_W  = 8,
    parameter int ACC_W   = 32,
    parameter int COLS    = 8,
    parameter int ROWS    = 4,
    parameter int MAX_LEN = 1024,
    parameter int PRE_DLY = 4,
    localparam int LEN_W  = $clog2(MAX_LEN),
    localparam int NTAP   = ROWS * COLS,
    localparam int CA_W   = $clog2(NTAP)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  live_pix,
    input  logic [PIX_W-1:0]  prev_pix,
    input  logic              field_sel,
    input  logic [LEN_W-1:0]  cfg_line_len_m1,
    input  logic [1:0]        cfg_pre_dly,
    input  logic              coef_we,
    input  logic [CA_W-1:0]   coef_addr,
    input  logic [COEF_W-1:0] coef_data,
    output logic              out_valid,
    output logic [ACC_W-1:0]  out_sum,
    output logic [PIX_W-1:0]  out_last
);
    logic [PIX_W-1:0]       pre_q    [PRE_DLY];
    logic [PIX_W-1:0]       row_in   [ROWS];
    logic [PIX_W-1:0]       ld_out   [ROWS];
    logic [COLS*PIX_W-1:0]  row_taps [ROWS];
    logic [COEF_W-1:0]      coef_q   [NTAP];
    logic [NTAP*PIX_W-1:0]  win_flat;
    logic [NTAP*COEF_W-1:0] coef_flat;
    logic [ACC_W-1:0]       sum_d;
    logic                   v1;

    // optional fixed input delay ahead of the window and line stores
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PRE_DLY; i++) pre_q[i] <= '0;
        end else if (in_valid) begin
            pre_q[0] <= live_pix;
            for (int i = 1; i < PRE_DLY; i++) pre_q[i] <= pre_q[i-1];
        end
    end

    assign row_in[0] = (cfg_pre_dly == 2'b01) ? pre_q[PRE_DLY-1] : live_pix;
    assign ld_out[0] = '0;

    generate
        for (genvar r = 1; r < ROWS; r++) begin : g_line
            cv_line_delay #(.PIX_W(PIX_W), .MAX_LEN(MAX_LEN)) u_ld (
                .clk    (clk),
                .rst    (rst),
                .en     (in_valid),
                .len_m1 (cfg_line_len_m1),
                .din    (row_in[r-1]),
                .dout   (ld_out[r])
            );
            if (r == 1) begin : g_field
                assign row_in[r] = field_sel ? prev_pix : ld_out[r];
            end else begin : g_chain
                assign row_in[r] = ld_out[r];
            end
        end

        for (genvar r = 0; r < ROWS; r++) begin : g_taps
            cv_row_taps #(.PIX_W(PIX_W), .COLS(COLS)) u_taps (
                .clk  (clk),
                .rst  (rst),
                .en   (in_valid),
                .din  (row_in[r]),
                .taps (row_taps[r])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NTAP; i++) coef_q[i] <= '0;
        end else if (coef_we) begin
            coef_q[coef_addr] <= coef_data;
        end
    end

    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            win_flat[r*COLS*PIX_W +: COLS*PIX_W] = row_taps[r];
        end
        for (int i = 0; i < NTAP; i++) begin
            coef_flat[i*COEF_W +: COEF_W] = coef_q[i];
        end
    end

    cv_mac #(.PIX_W(PIX_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .NTAP(NTAP)) u_mac (
        .win   (win_flat),
        .coefs (coef_flat),
        .sum   (sum_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            v1        <= 1'b0;
            out_valid <= 1'b0;
            out_sum   <= '0;
            out_last  <= '0;
        end else begin
            v1        <= in_valid;
            out_valid <= v1;
            if (v1) begin
                out_sum  <= sum_d;
                out_last <= row_taps[ROWS-1][PIX_W-1:0];
            end
        end
    end

    // R7: a result appears only two clocks after an accepted pixel
    p_valid_lat_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2));

    // R7: the sum holds while no result is flagged
    p_sum_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_sum));

    // R9: the row-3 pixel output moves together with the sum
    p_last_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_last));
endmodule

// File: tb/tb_win_convolver.sv
module tb_win_convolver;
    localparam int CLK_P = 10;
    localparam int MAXN  = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  live_pix = '0;
    logic [7:0]  prev_pix = '0;
    logic        field_sel = 1'b0;
    logic [9:0]  cfg_line_len_m1 = '0;
    logic [1:0]  cfg_pre_dly = '0;
    logic        coef_we = 1'b0;
    logic [4:0]  coef_addr = '0;
    logic [7:0]  coef_data = '0;
    logic        out_valid;
    logic [31:0] out_sum;
    logic [7:0]  out_last;

    win_convolver dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .live_pix(live_pix),
        .prev_pix(prev_pix), .field_sel(field_sel),
        .cfg_line_len_m1(cfg_line_len_m1), .cfg_pre_dly(cfg_pre_dly),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
        .out_valid(out_valid), .out_sum(out_sum), .out_last(out_last)
    );

    always #(CLK_P/2) clk = ~clk;

    int live [MAXN];
    int prev [MAXN];
    int cf   [2][32];
    int L, pre, fs, sw_at, out_idx;
    int vecs, bad;
    string tag;
    bit h1, h2;
    int unsigned seed = 32'h1234_5678;

    function automatic int unsigned rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    function automatic int s_val(int n);
        if (pre == 1) n = n - 4;
        if (n < 0) return 0;
        return live[n];
    endfunction

    function automatic int row_val(int r, int n);
        if (n < 0) return 0;
        if (r == 0) return s_val(n);
        if (r == 1) return fs ? prev[n] : s_val(n - L);
        return row_val(r - 1, n - L);
    endfunction

    function automatic int exp_sum(int n);
        int acc = 0;
        int k = (n >= sw_at) ? 1 : 0;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 8; c++)
                acc += cf[k][r*8+c] * row_val(r, n - c);
        return acc;
    endfunction

    task automatic chk(string req, bit ok, int act, int expv);
        vecs++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            h1 = 1'b0;
            h2 = 1'b0;
        end else begin
            chk("R7 valid latency", out_valid == h2, int'(out_valid), int'(h2));
            if (out_valid) begin
                chk(tag, $signed(out_sum) == exp_sum(out_idx), $signed(out_sum), exp_sum(out_idx));
                chk("R9 last row pixel", int'(out_last) == row_val(3, out_idx), int'(out_last), row_val(3, out_idx));
                out_idx++;
            end
            h2 = h1;
            h1 = in_valid;
        end
    end

    task automatic load_coefs(int k);
        for (int a = 0; a < 32; a++) begin
            @(posedge clk); #1;
            coef_we   = 1'b1;
            coef_addr = 5'(a);
            coef_data = 8'(cf[k][a]);
        end
        @(posedge clk); #1;
        coef_we = 1'b0;
    endtask

    task automatic make_coefs(int k, int mode);
        for (int a = 0; a < 32; a++) begin
            case (mode)
                1: cf[k][a] = -128;
                2: cf[k][a] = ((a / 8) < 3 && (a % 8) < 3) ? int'(rnd() % 255) - 127 : 0;
                default: cf[k][a] = int'(rnd() % 256) - 128;
            endcase
        end
    endtask

    task automatic run(string t, int len, int p, int f, int n, int stall,
                       int pixmode, int coefmode, bit reload);
        tag = t;
        L = len; pre = p; fs = f;
        sw_at = reload ? n / 2 : MAXN + 1;
        for (int i = 0; i < n; i++) begin
            case (pixmode)
                0: live[i] = (i * 7 + 3) & 255;
                2: live[i] = 255;
                default: live[i] = int'(rnd() & 255);
            endcase
            prev[i] = (pixmode == 2) ? 255 : int'(rnd() & 255);
        end
        make_coefs(0, coefmode);
        make_coefs(1, 0);
        @(posedge clk); #1;
        rst = 1'b1; in_valid = 1'b0;
        cfg_line_len_m1 = 10'(len - 1);
        cfg_pre_dly = 2'(p);
        field_sel = f[0];
        out_idx = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R4 reset state", !out_valid && out_sum == 0 && out_last == 0,
            int'(out_sum), 0);
        load_coefs(0);
        begin
            int i = 0;
            int cyc = 0;
            while (i < n) begin
                @(posedge clk); #1;
                if (reload && i == n / 2 && sw_at >= 0) begin
                    in_valid = 1'b0;
                    load_coefs(1);
                    sw_at = -sw_at - 1;
                    @(posedge clk); #1;
                end
                if (stall > 0 && (cyc % stall) == stall - 1) begin
                    in_valid = 1'b0;
                    live_pix = 8'hA5;
                    prev_pix = 8'h5A;
                end else begin
                    in_valid = 1'b1;
                    live_pix = 8'(live[i]);
                    prev_pix = 8'(prev[i]);
                    i++;
                end
                cyc++;
            end
        end
        if (sw_at < 0) sw_at = -sw_at - 1;
        @(posedge clk); #1;
        in_valid = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R7 output count", out_idx == n, out_idx, n);
    endtask

    initial begin
        vecs = 0; bad = 0; sw_at = MAXN + 1; tag = "R2";
        run("R2 window sum",         1, 0, 0, 120, 0, 0, 0, 1'b0);
        run("R6 pre-delay 01",       5, 1, 0, 150, 0, 1, 0, 1'b0);
        run("R6 code 10 no delay",   9, 2, 0, 150, 0, 1, 0, 1'b0);
        run("R6 code 11 no delay",   4, 3, 0, 100, 0, 1, 0, 1'b0);
        run("R5 previous field row", 7, 0, 1, 160, 0, 1, 0, 1'b0);
        run("R3 extreme sum",       16, 0, 0, 120, 0, 2, 1, 1'b0);
        run("R10 zero-filled 3x3",   6, 0, 0, 140, 0, 1, 2, 1'b0);
        run("R8 stalls ignored",     3, 1, 1, 200, 3, 1, 0, 1'b0);
        run("R11 coefficient reload",5, 0, 0, 200, 5, 1, 0, 1'b1);
        run("R1 full line length", 1024, 0, 0, 3300, 0, 1, 0, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule